// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns a local-bus address into a PCI bus address and a cycle type. It has a small set of programmable windows, three by default. Each window is described by a pair of registers. The base register gives the local start address, the size and an enable bit. The map register gives the PCI start address, the cycle type and a low-address control bit. On every request the windows are tried in ascending index order, and the first enabled window that contains the address supplies the translation. Software can therefore widen window 0 so that it hides window 1, then point window 1 at configuration space, without the two windows fighting over the same addresses.

For configuration windows, the offset inside the window carries the device, function and register fields that software composes. The map register adds two things to this. Its upper bits supply high one-hot device-select lines for type 0 cycles. Its bit 0 either forces PCI A1:A0 to zero (type 0) or passes the host's low two bits through (type 1, where the host supplies 01). Registers are written and read through a simple select/data port. Translation results appear one clock after the request.

Top module: `xlt_window_xlate`

## Requirements
- R1: After reset every base and map register reads zero, so every window is disabled, and rsp_valid is low.
- R2: When more than one enabled window contains the address, the window with the lowest index supplies the translation, and rsp_win reports that index.
- R3: Base register layout: bits 31:20 hold the local start address in 1 MB units, bit 8 is the enable, and bits 3:0 hold a size code k giving a window of 2^(20+k) bytes. Codes above 11 are treated as 11. The window matches when the address bits above 20+k equal the base bits there. The last byte of a window hits; the first byte past it does not.
- R4: Map register layout: bits 15:4 hold PCI A31:A20 and bits 3:1 hold the cycle type (001 I/O, 011 memory, 111 burst memory, 101 configuration). The PCI address is the map base plus the offset of the local address within the window, modulo 2^32. rsp_cyc is the map's type field.
- R5: For a window whose type is 101, map bit 0 = 0 forces PCI A1:A0 to 00, and map bit 0 = 1 passes the host bits through. For other types the low bits always pass through.
- R6: An address that no enabled window contains gives rsp_hit = 0, rsp_cyc = 000, rsp_addr = 0 and rsp_win = 0. A window with its enable bit clear never matches.
- R7: In a configuration window, map bit n for n in 8..15 sets PCI address bit n+16. A type 0 slot s above 12 is therefore selected by map bit s-5 (PCI bit s+11), while the offset still carries the function and register fields.
- R8: A request on req_valid produces rsp_valid and its result exactly one cycle later. rsp_valid is low in a cycle after no request. A register write is seen by a request in the next cycle. A request in the same cycle as the write sees the old contents.
- R9: reg_rdata shows, one cycle later, the register picked by reg_sel (selector = 2*window + 1 for map, + 0 for base). Only the stored fields are kept: base reads back with mask 0xFFF0010F, and map reads back its low 16 bits. Selectors beyond the last window ignore writes and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | SELW (3) | Register selector: 2*window + (1 map, 0 base) |
| reg_wdata | input | AW (32) | Register write data |
| reg_rdata | output | AW (32) | Registered read data for reg_sel |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | AW (32) | Local-bus address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after req_valid |
| rsp_hit | output | 1 | A window matched |
| rsp_addr | output | AW (32) | Translated PCI address |
| rsp_cyc | output | 3 | PCI cycle type of the matching window |
| rsp_win | output | WIW (2) | Index of the matching window |

## Verification
The bench uses the default parameters: three windows, a 32-bit address and 1 MB granularity. With these the size codes reach the 16 MB, 256 MB and 512 MB windows, as well as the clamped 2 GB window whose translation wraps past 2^32. Three windows are enough to show window 0 growing over window 1 while window 1 is turned into a configuration window, both for a request in the same cycle as the register write and for one in the next cycle. The 16-bit map lets type 0 slots above 12 be selected through the high map bits alongside type 1 addresses.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  // Cycle type codes carried in map bits 3:1
  localparam logic [2:0] CYC_NONE  = 3'b000;
  localparam logic [2:0] CYC_IO    = 3'b001;
  localparam logic [2:0] CYC_MEM   = 3'b011;
  localparam logic [2:0] CYC_CFG   = 3'b101;
  localparam logic [2:0] CYC_BURST = 3'b111;

  // Fixed field positions inside the registers
  localparam int EN_BIT   = 8;  // base register enable
  localparam int SZW      = 4;  // base register size code width
  localparam int MAP_LOW  = 4;  // first PCI address bit in map register
  localparam int LOWEN_BIT = 0; // map: pass host A1:A0 for config cycles

endpackage

// File: rtl/xlt_regfile.sv
module xlt_regfile #(
  parameter int NWIN = 3,
  parameter int AW   = 32,
  parameter int MBS  = 20,
  localparam int MAPW = AW - MBS + xlt_pkg::MAP_LOW,
  localparam int SELW = $clog2(NWIN) + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [SELW-1:0]            sel,
  input  logic [AW-1:0]              wdata,
  output logic [AW-1:0]              rdata,
  output logic [NWIN-1:0][AW-1:0]    base_o,
  output logic [NWIN-1:0][MAPW-1:0]  map_o
);
  import xlt_pkg::*;

  localparam logic [AW-1:0] BASE_KEEP =
      ({AW{1'b1}} << MBS) | (AW'(1) << EN_BIT) | AW'((1 << SZW) - 1);

  logic [SELW-2:0] sel_win;
  logic            sel_map;
  logic            sel_ok;

  assign sel_win = sel[SELW-1:1];
  assign sel_map = sel[0];
  assign sel_ok  = (int'(sel_win) < NWIN);

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      logic [AW-1:0]   base_q;
      logic [MAPW-1:0] map_q;
      logic            hit_me;
      assign hit_me = we && (int'(sel_win) == w);

      always_ff @(posedge clk) begin
        if (rst) begin
          base_q <= '0;
          map_q  <= '0;
        end else if (hit_me) begin
          if (sel_map) map_q  <= wdata[MAPW-1:0];
          else         base_q <= wdata & BASE_KEEP;
        end
      end

      assign base_o[w] = base_q;
      assign map_o[w]  = map_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (!sel_ok) begin
      rdata <= '0;
    end else if (sel_map) begin
      rdata <= AW'(map_o[sel_win]);
    end else begin
      rdata <= base_o[sel_win];
    end
  end

endmodule

// File: rtl/xlt_win_match.sv
module xlt_win_match #(
  parameter int AW  = 32,
  parameter int MBS = 20,
  localparam int MAPW = AW - MBS + xlt_pkg::MAP_LOW,
  localparam int MAXK = AW - MBS - 1
) (
  input  logic [AW-1:0]   base,
  input  logic [MAPW-1:0] map,
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [AW-1:0]   pci_addr,
  output logic [2:0]      cyc
);
  import xlt_pkg::*;

  logic [SZW-1:0] code;
  logic [SZW-1:0] k_eff;
  logic [AW-1:0]  hi_mask;
  logic [AW-1:0]  offset;
  logic [AW-1:0]  pbase;
  logic [AW-1:0]  sum;
  logic           enable;

  assign code   = base[SZW-1:0];
  assign enable = base[EN_BIT];
  assign k_eff  = (int'(code) > MAXK) ? SZW'(MAXK) : code;

  always_comb begin
    hi_mask = {AW{1'b1}} << (MBS + int'(k_eff));
    offset  = addr & ~hi_mask;
    hit     = enable && (((addr ^ base) & hi_mask) == '0);
    pbase   = {map[MAPW-1:MAP_LOW], {MBS{1'b0}}};
    sum     = pbase + offset;
    cyc     = map[3:1];
    pci_addr = sum;
    if ((cyc == CYC_CFG) && !map[LOWEN_BIT]) begin
      pci_addr[1:0] = 2'b00;
    end
  end

endmodule

// File: rtl/xlt_prio_sel.sv
module xlt_prio_sel #(
  parameter int NWIN = 3,
  parameter int AW   = 32,
  localparam int WIW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [NWIN-1:0]          hit_vec,
  input  logic [NWIN-1:0][AW-1:0]  addr_vec,
  input  logic [NWIN-1:0][2:0]     cyc_vec,
  output logic                     any_hit,
  output logic [WIW-1:0]           win,
  output logic [AW-1:0]            addr,
  output logic [2:0]               cyc
);

  always_comb begin
    any_hit = 1'b0;
    win     = '0;
    addr    = '0;
    cyc     = 3'b000;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win     = WIW'(i);
        addr    = addr_vec[i];
        cyc     = cyc_vec[i];
      end
    end
  end

endmodule

// File: rtl/xlt_window_xlate.sv
module xlt_window_xlate #(
  parameter int NWIN = 3,
  parameter int AW   = 32,
  parameter int MBS  = 20,
  localparam int SELW = $clog2(NWIN) + 1,
  localparam int WIW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [SELW-1:0] reg_sel,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [AW-1:0]   rsp_addr,
  output logic [2:0]      rsp_cyc,
  output logic [WIW-1:0]  rsp_win
);
  import xlt_pkg::*;

  localparam int MAPW = AW - MBS + MAP_LOW;

  logic [NWIN-1:0][AW-1:0]   base_w;
  logic [NWIN-1:0][MAPW-1:0] map_w;
  logic [NWIN-1:0]           hit_vec;
  logic [NWIN-1:0]           en_vec;
  logic [NWIN-1:0][AW-1:0]   addr_vec;
  logic [NWIN-1:0][2:0]      cyc_vec;
  logic                      sel_hit;
  logic [WIW-1:0]            sel_win;
  logic [AW-1:0]             sel_addr;
  logic [2:0]                sel_cyc;

  xlt_regfile #(.NWIN(NWIN), .AW(AW), .MBS(MBS)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .base_o (base_w),
    .map_o  (map_w)
  );

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_match
      assign en_vec[w] = base_w[w][EN_BIT];
      xlt_win_match #(.AW(AW), .MBS(MBS)) u_match (
        .base     (base_w[w]),
        .map      (map_w[w]),
        .addr     (req_addr),
        .hit      (hit_vec[w]),
        .pci_addr (addr_vec[w]),
        .cyc      (cyc_vec[w])
      );
    end
  endgenerate

  xlt_prio_sel #(.NWIN(NWIN), .AW(AW)) u_prio (
    .hit_vec  (hit_vec),
    .addr_vec (addr_vec),
    .cyc_vec  (cyc_vec),
    .any_hit  (sel_hit),
    .win      (sel_win),
    .addr     (sel_addr),
    .cyc      (sel_cyc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
      rsp_cyc   <= CYC_NONE;
      rsp_win   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit  <= sel_hit;
        rsp_addr <= sel_hit ? sel_addr : '0;
        rsp_cyc  <= sel_hit ? sel_cyc : CYC_NONE;
        rsp_win  <= sel_hit ? sel_win : '0;
      end
    end
  end

endmodule

// File: rtl/xlt_window_xlate_chk.sv
module xlt_window_xlate_chk #(
  parameter int NWIN = 3,
  parameter int AW   = 32,
  localparam int WIW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [AW-1:0]   rsp_addr,
  input logic [2:0]      rsp_cyc,
  input logic [WIW-1:0]  rsp_win,
  input logic [NWIN-1:0] hit_vec,
  input logic [NWIN-1:0] en_vec,
  input logic            sel_hit,
  input logic [WIW-1:0]  sel_win
);

  // R2: chosen window matches and no lower-index window matches
  a_r2_first_match: assert property (@(posedge clk) disable iff (rst)
    sel_hit |-> (hit_vec[sel_win] &&
                 ((hit_vec & ~({NWIN{1'b1}} << sel_win)) == '0)));

  // R6: a disabled window never reports a match
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (hit_vec & ~en_vec) == '0);

  // R6: a miss carries no cycle, no address and window 0
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_cyc == 3'b000 && rsp_addr == '0 &&
                                 rsp_win == '0));

  // R8: one-cycle response latency
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R8: no spurious responses
  a_r8_no_extra: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R8: result held while idle
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_addr) && $stable(rsp_cyc) && $stable(rsp_hit)));

endmodule

bind xlt_window_xlate xlt_window_xlate_chk #(.NWIN(NWIN), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_addr  (rsp_addr),
  .rsp_cyc   (rsp_cyc),
  .rsp_win   (rsp_win),
  .hit_vec   (hit_vec),
  .en_vec    (en_vec),
  .sel_hit   (sel_hit),
  .sel_win   (sel_win)
);

// File: tb/sim_xlt_window_xlate.sv
module sim_xlt_window_xlate;

  localparam int NWIN = 3;
  localparam int AW   = 32;
  localparam int SELW = 3;
  localparam int WIW  = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_we = 1'b0;
  logic [SELW-1:0] reg_sel = '0;
  logic [AW-1:0]   reg_wdata = '0;
  logic [AW-1:0]   reg_rdata;
  logic            req_valid = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic            rsp_valid;
  logic            rsp_hit;
  logic [AW-1:0]   rsp_addr;
  logic [2:0]      rsp_cyc;
  logic [WIW-1:0]  rsp_win;

  always #10 clk = ~clk;  // 50 MHz

  xlt_window_xlate #(.NWIN(NWIN), .AW(AW), .MBS(20)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_addr(rsp_addr), .rsp_cyc(rsp_cyc), .rsp_win(rsp_win)
  );

  typedef struct {
    logic          hit;
    logic [31:0]   addr;
    logic [2:0]    cyc;
    logic [1:0]    win;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected results as responses appear
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R8 unexpected response actual=%08h expected=none", rsp_addr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " hit"}, 32'(rsp_hit), 32'(e.hit));
        check({e.tag, " addr"}, rsp_addr, e.addr);
        check({e.tag, " cyc"}, 32'(rsp_cyc), 32'(e.cyc));
        check({e.tag, " win"}, 32'(rsp_win), 32'(e.win));
      end
    end
  end

  task automatic push_exp(input logic h, input logic [31:0] a,
                          input logic [2:0] c, input logic [1:0] w,
                          input string tag);
    exp_t e;
    e.hit = h; e.addr = a; e.cyc = c; e.win = w; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send_req(input logic [31:0] a, input logic h,
                          input logic [31:0] ea, input logic [2:0] c,
                          input logic [1:0] w, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    push_exp(h, ea, c, w, tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [SELW-1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [SELW-1:0] s, input logic [31:0] e,
                          input string tag);
    @(negedge clk);
    reg_sel = s;
    @(negedge clk);
    check(tag, reg_rdata, e);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    for (int s = 0; s < 6; s++) rd_check(SELW'(s), 32'h0, "R1 register zero");
    send_req(32'h4000_0000, 1'b0, 32'h0, 3'b000, 2'd0, "R1 R6 all disabled");

    // Memory windows: 256M at 0x40000000, 256M at 0x50000000, 16M IO at 0x60000000
    wr_reg(3'd0, 32'h4000_0108); wr_reg(3'd1, 32'h0000_0006);
    wr_reg(3'd2, 32'h5000_0108); wr_reg(3'd3, 32'h0000_100E);
    wr_reg(3'd4, 32'h6000_0104); wr_reg(3'd5, 32'h0000_0002);
    send_req(32'h4123_4567, 1'b1, 32'h0123_4567, 3'b011, 2'd0, "R4 mem window0");
    send_req(32'h5ABC_DEF3, 1'b1, 32'h1ABC_DEF3, 3'b111, 2'd1, "R4 burst window1");
    send_req(32'h60FF_FFFF, 1'b1, 32'h00FF_FFFF, 3'b001, 2'd2, "R3 last byte of io window");
    send_req(32'h6100_0000, 1'b0, 32'h0, 3'b000, 2'd0, "R3 R6 first byte past window");
    send_req(32'h3FFF_FFFF, 1'b0, 32'h0, 3'b000, 2'd0, "R6 below all windows");

    // Same-cycle write and request: old window set applies (R8)
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 32'h4000_0109;
    req_valid = 1'b1; req_addr = 32'h5000_0010;
    push_exp(1'b1, 32'h1000_0010, 3'b111, 2'd1, "R8 same-cycle sees old");
    @(negedge clk);
    reg_we = 1'b0;
    req_addr = 32'h5000_0010;
    push_exp(1'b1, 32'h1000_0010, 3'b011, 2'd0, "R2 R8 window0 grown hides window1");
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R8 idle cycle no response", 32'(rsp_valid), 32'd0);
    send_req(32'h5ABC_DEF3, 1'b1, 32'h1ABC_DEF3, 3'b011, 2'd0, "R2 overlap lowest index");

    // Window 1 to 16M config space at 0x61000000, type 0 (A1:A0 forced)
    wr_reg(3'd2, 32'h6100_0104); wr_reg(3'd3, 32'h0000_000A);
    send_req(32'h6100_4217, 1'b1, 32'h0000_4214, 3'b101, 2'd1, "R5 type0 low bits forced");
    wr_reg(3'd3, 32'h0000_040A);
    send_req(32'h6100_0108, 1'b1, 32'h0400_0108, 3'b101, 2'd1, "R7 type0 slot 15 via map");
    wr_reg(3'd3, 32'h0000_000B);
    send_req(32'h6107_210D, 1'b1, 32'h0007_210D, 3'b101, 2'd1, "R5 type1 low bits passed");
    send_req(32'h6000_0003, 1'b1, 32'h0000_0003, 3'b001, 2'd2, "R5 io low bits untouched");

    // Disable window 2
    wr_reg(3'd4, 32'h6000_0004);
    send_req(32'h6000_0003, 1'b0, 32'h0, 3'b000, 2'd0, "R6 disabled window");

    // Size code 15 clamps to 2G at 0x80000000
    wr_reg(3'd4, 32'h8000_010F);
    rd_check(3'd4, 32'h8000_010F, "R9 base readback");
    send_req(32'hF000_0004, 1'b1, 32'h7000_0004, 3'b001, 2'd2, "R3 size code clamp");
    wr_reg(3'd5, 32'h0000_C002);
    send_req(32'hF000_0004, 1'b1, 32'h3000_0004, 3'b001, 2'd2, "R4 address wraps");

    // Field masking and out-of-range selectors
    wr_reg(3'd0, 32'hFFFF_FFFF);
    rd_check(3'd0, 32'hFFF0_010F, "R9 base field mask");
    wr_reg(3'd1, 32'hFFFF_FFFF);
    rd_check(3'd1, 32'h0000_FFFF, "R9 map field mask");
    wr_reg(3'd6, 32'h1234_5678);
    rd_check(3'd6, 32'h0, "R9 out-of-range base");
    wr_reg(3'd7, 32'h1234_5678);
    rd_check(3'd7, 32'h0, "R9 out-of-range map");
    rd_check(3'd5, 32'h0000_C002, "R9 window2 map kept");

    repeat (3) @(negedge clk);
    check("R8 queue drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule